// File: doc/BRIEF.md
# Unrolled CORDIC Rectangular-to-Polar Converter

This block turns a signed Cartesian sample (x, y) into a magnitude and a four-quadrant angle in radians. It uses the CORDIC vectoring iteration. All micro-rotations are unrolled into one combinational chain with no registers between stages, so a new sample can be accepted on every clock. Each stage shifts by a constant amount, which is only wiring, and adds a constant arctangent.

The vector is first folded into the right half-plane by conditional negation, and the half-turn that this removes is recorded. The micro-rotation chain then drives the residual y toward zero while it accumulates the angle. A finishing stage adds the recorded half-turn back, bounds the angle to the signed range of pi, and rounds it to the output format. The same stage removes the fixed CORDIC gain from the magnitude with a constant shift-and-add multiplier and saturates the result. The gain correction is applied only to the magnitude.

Inputs and outputs are both registered, and a valid strobe travels alongside the data. All data words are signed 12-bit fixed point with 8 fractional bits (Q4.8), and the angle is expressed in radians in that same format.

Top module: `polar_conv`

## Requirements
- R1: While the synchronous active-high reset is asserted, on every clock out_valid, out_mag and out_angle are 0.
- R2: A sample presented with in_valid high at clock edge N yields out_valid high and its results after edge N+1. Samples presented on consecutive edges yield results on consecutive edges. Without a sample at edge N, out_valid is low after edge N+1.
- R3: out_mag (Q4.8, non-negative) is within 4 LSB of the rounded value of sqrt(x*x + y*y) whenever that value is below the saturation limit.
- R4: For inputs whose true magnitude is at least 1.0 (256 LSB), out_angle (Q4.8 radians) is within 4 LSB of atan2(y, x) rounded to the nearest LSB.
- R5: Quadrant cases come out with the correct sign and quadrant, each within 3 LSB. (1.0, 1.0) gives 201 (pi/4), (-1.0, -1.0) gives -603 (-3pi/4), (0, 1.0) gives 402 (pi/2) and (0, -1.0) gives -402.
- R6: out_angle never leaves the range -804..804 (about -pi..+pi). A vector on the negative x axis (x < 0, y = 0) gives a positive angle within 2 LSB of 804.
- R7: When the true magnitude is 2051 LSB or more, out_mag is exactly 2047, the largest positive code.
- R8: Input (0, 0) gives out_mag = 0 and out_angle = 0.
- R9: While no sample is presented, out_mag and out_angle keep their last values even if in_x and in_y change, and out_valid stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is presented on in_x / in_y this cycle |
| in_x | input | 12 | Signed Q4.8 real (x) component |
| in_y | input | 12 | Signed Q4.8 imaginary (y) component |
| out_valid | output | 1 | out_mag / out_angle hold a new result |
| out_mag | output | 12 | Gain-corrected, saturated magnitude, Q4.8 |
| out_angle | output | 12 | Signed angle in radians, Q4.8 |

## Verification
A near-exhaustive grid, stepping both components by 32 LSB across the whole signed input range, covers all four quadrants, both axes, the origin and the corners where the magnitude saturates. Every grid point is compared with magnitude and atan2 values that the bench computes in floating point. Points on the negative x axis and just either side of it show whether the half-turn correction lands on the right side of the ±pi seam. The exact quadrant probes show whether the folding sign is right and whether the x = 0 case is handled. A short back-to-back stream separates one-result-per-clock throughput from one-shot behaviour. An idle stretch with changing inputs shows that the output registers hold their values.

// File: rtl/polar_conv_pkg.sv
`timescale 1ns/1ps
package polar_conv_pkg;

  // Half-turn correction recorded by the folding stage
  typedef enum logic [1:0] {
    QC_NONE   = 2'd0,
    QC_ADD_PI = 2'd1,
    QC_SUB_PI = 2'd2
  } quad_fix_e;

  // pi and atan(2^-i), scaled by 2^30
  localparam longint PI_S30 = 64'sd3373259426;

  function automatic longint atan_s30(input int i);
    case (i)
      0:  return 64'sd843314857;
      1:  return 64'sd497837829;
      2:  return 64'sd263043837;
      3:  return 64'sd133525159;
      4:  return 64'sd67021687;
      5:  return 64'sd33543516;
      6:  return 64'sd16775851;
      7:  return 64'sd8388437;
      8:  return 64'sd4194283;
      9:  return 64'sd2097149;
      default: return (i < 31) ? (64'sd1 <<< (30 - i)) : 64'sd0;
    endcase
  endfunction

  function automatic int round_s30(input longint v, input int frac);
    return int'((v + (64'sd1 <<< (29 - frac))) >>> (30 - frac));
  endfunction

  function automatic int atan_q(input int i, input int frac);
    return round_s30(atan_s30(i), frac);
  endfunction

  function automatic int pi_q(input int frac);
    return round_s30(PI_S30, frac);
  endfunction

endpackage

// File: rtl/polar_premap.sv
`timescale 1ns/1ps
// Folds the vector into the right half-plane and records the half-turn.
module polar_premap
  import polar_conv_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int GUARD  = 2,
  parameter int XW     = DATA_W + 2 + GUARD
) (
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] y_i,
  output logic signed [XW-1:0]     x_o,
  output logic signed [XW-1:0]     y_o,
  output quad_fix_e                fix_o,
  output logic                     zero_o
);
  logic signed [XW-1:0] x_e, y_e;

  assign x_e = XW'(x_i) <<< GUARD;
  assign y_e = XW'(y_i) <<< GUARD;
  assign zero_o = (x_i == '0) && (y_i == '0);

  always_comb begin
    if (x_i[DATA_W-1]) begin
      x_o   = -x_e;
      y_o   = -y_e;
      fix_o = y_i[DATA_W-1] ? QC_SUB_PI : QC_ADD_PI;
    end else begin
      x_o   = x_e;
      y_o   = y_e;
      fix_o = QC_NONE;
    end
  end
endmodule

// File: rtl/polar_microrot.sv
`timescale 1ns/1ps
// One vectoring micro-rotation; the shift is a constant, so it is wiring only.
module polar_microrot #(
  parameter int XW     = 16,
  parameter int ZW     = 14,
  parameter int SHIFT  = 0,
  parameter int ATAN_Q = 0
) (
  input  logic signed [XW-1:0] x_i,
  input  logic signed [XW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  output logic signed [XW-1:0] x_o,
  output logic signed [XW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);
  localparam logic signed [ZW-1:0] A_Z = ZW'(ATAN_Q);

  logic signed [XW-1:0] x_sh, y_sh;

  assign x_sh = x_i >>> SHIFT;
  assign y_sh = y_i >>> SHIFT;

  always_comb begin
    if (!y_i[XW-1]) begin
      x_o = x_i + y_sh;
      y_o = y_i - x_sh;
      z_o = z_i + A_Z;
    end else begin
      x_o = x_i - y_sh;
      y_o = y_i + x_sh;
      z_o = z_i - A_Z;
    end
  end
endmodule

// File: rtl/polar_finish.sv
`timescale 1ns/1ps
// Gain removal, saturation, half-turn correction and output rounding.
module polar_finish
  import polar_conv_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int GUARD   = 2,
  parameter int XW      = DATA_W + 2 + GUARD,
  parameter int ZW      = DATA_W + GUARD,
  parameter int KQ_W    = 16,
  parameter int INV_K_Q = 39797,
  parameter int PI_Z    = 3217
) (
  input  logic signed [XW-1:0]     x_i,
  input  logic signed [ZW-1:0]     z_i,
  input  quad_fix_e                fix_i,
  input  logic                     zero_i,
  output logic [DATA_W-1:0]        mag_o,
  output logic signed [DATA_W-1:0] ang_o
);
  localparam int PW      = XW + KQ_W;
  localparam int MS      = KQ_W + GUARD;
  localparam int MAG_MAX = (1 << (DATA_W - 1)) - 1;
  localparam logic [KQ_W-1:0]     KQ    = KQ_W'(INV_K_Q);
  localparam logic [PW-1:0]       RND_M = PW'(1) << (MS - 1);
  localparam logic [PW-1:0]       MAX_P = PW'(MAG_MAX);
  localparam logic signed [ZW:0]  PI_E  = (ZW + 1)'(PI_Z);
  localparam logic signed [ZW:0]  RND_Z = (ZW + 1)'(1 << (GUARD - 1));

  // Constant multiply by 1/K as a sum of shifted copies
  logic [XW-1:0] x_u;
  logic [PW-1:0] terms [KQ_W];
  logic [PW-1:0] prod, scaled;

  assign x_u = x_i;

  for (genvar j = 0; j < KQ_W; j++) begin : g_term
    if (KQ[j]) begin : g_on
      assign terms[j] = PW'(x_u) << j;
    end else begin : g_off
      assign terms[j] = '0;
    end
  end

  always_comb begin
    prod = '0;
    for (int j = 0; j < KQ_W; j++) prod = prod + terms[j];
    scaled = (prod + RND_M) >> MS;
    mag_o  = (scaled > MAX_P) ? DATA_W'(MAG_MAX) : scaled[DATA_W-1:0];
  end

  // Half-turn correction bounded to the seam, then rounding
  logic signed [ZW:0] z_e, z_sum;

  assign z_e = (ZW + 1)'(z_i);

  always_comb begin
    case (fix_i)
      QC_ADD_PI: begin
        z_sum = z_e + PI_E;
        if (z_sum > PI_E) z_sum = PI_E;
      end
      QC_SUB_PI: begin
        z_sum = z_e - PI_E;
        if (z_sum < -PI_E) z_sum = -PI_E;
      end
      default: z_sum = z_e;
    endcase
    ang_o = zero_i ? '0 : DATA_W'((z_sum + RND_Z) >>> GUARD);
  end
endmodule

// File: rtl/polar_conv.sv
`timescale 1ns/1ps
module polar_conv
  import polar_conv_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int FRAC_W  = 8,
  parameter int STAGES  = 12,
  parameter int GUARD   = 2,
  parameter int KQ_W    = 16,
  parameter int INV_K_Q = 39797
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_x,
  input  logic signed [DATA_W-1:0] in_y,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_mag,
  output logic signed [DATA_W-1:0] out_angle
);
  localparam int XW     = DATA_W + 2 + GUARD;
  localparam int ZW     = DATA_W + GUARD;
  localparam int ZF     = FRAC_W + GUARD;
  localparam int PI_Z   = pi_q(ZF);
  localparam int PI_OUT = pi_q(FRAC_W);
  localparam logic signed [XW-1:0]     RES_LIM = XW'(64);
  localparam logic signed [DATA_W-1:0] ANG_LIM = DATA_W'(PI_OUT);

  // Input register
  logic                     v_q;
  logic signed [DATA_W-1:0] x_q, y_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
      x_q <= '0;
      y_q <= '0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        x_q <= in_x;
        y_q <= in_y;
      end
    end
  end

  // Folding into the right half-plane
  logic signed [XW-1:0] xs [STAGES+1];
  logic signed [XW-1:0] ys [STAGES+1];
  logic signed [ZW-1:0] zs [STAGES+1];
  quad_fix_e            fix;
  logic                 zero_in;

  polar_premap #(.DATA_W(DATA_W), .GUARD(GUARD), .XW(XW)) u_premap (
    .x_i(x_q), .y_i(y_q), .x_o(xs[0]), .y_o(ys[0]),
    .fix_o(fix), .zero_o(zero_in)
  );
  assign zs[0] = '0;

  // R4: the folded vector always lies in the right half-plane
  a_r4_premap_right: assert property (@(posedge clk) disable iff (rst)
    v_q |-> !xs[0][XW-1]);

  // Unrolled micro-rotation chain, no registers between stages
  for (genvar i = 0; i < STAGES; i++) begin : g_rot
    polar_microrot #(.XW(XW), .ZW(ZW), .SHIFT(i), .ATAN_Q(atan_q(i, ZF))) u_rot (
      .x_i(xs[i]), .y_i(ys[i]), .z_i(zs[i]),
      .x_o(xs[i+1]), .y_o(ys[i+1]), .z_o(zs[i+1])
    );
  end

  // R4: the chain has driven the residual y close to zero
  a_r4_residual_small: assert property (@(posedge clk) disable iff (rst)
    v_q |-> (ys[STAGES] < RES_LIM) && (ys[STAGES] > -RES_LIM));

  logic [DATA_W-1:0]        mag_c;
  logic signed [DATA_W-1:0] ang_c;

  polar_finish #(
    .DATA_W(DATA_W), .GUARD(GUARD), .XW(XW), .ZW(ZW),
    .KQ_W(KQ_W), .INV_K_Q(INV_K_Q), .PI_Z(PI_Z)
  ) u_finish (
    .x_i(xs[STAGES]), .z_i(zs[STAGES]), .fix_i(fix), .zero_i(zero_in),
    .mag_o(mag_c), .ang_o(ang_c)
  );

  // Output register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mag   <= '0;
      out_angle <= '0;
    end else begin
      out_valid <= v_q;
      if (v_q) begin
        out_mag   <= mag_c;
        out_angle <= ang_c;
      end
    end
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !v_q |=> !out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !v_q |=> $stable(out_mag) && $stable(out_angle));

  a_r6_angle_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_angle <= ANG_LIM) && (out_angle >= -ANG_LIM));

  a_r8_origin: assert property (@(posedge clk) disable iff (rst)
    (v_q && x_q == '0 && y_q == '0) |=> (out_mag == '0) && (out_angle == '0));

endmodule

// File: tb/test_polar_conv.sv
`timescale 1ns/1ps
module test_polar_conv;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic signed [11:0] in_x = '0;
  logic signed [11:0] in_y = '0;
  logic              out_valid;
  logic [11:0]       out_mag;
  logic signed [11:0] out_angle;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  polar_conv i_polar_conv (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_mag(out_mag), .out_angle(out_angle)
  );

  task automatic expect_near(input string req, input string what,
                             input int act, input int exp, input int tol);
    int d;
    n_checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d (tol %0d)", req, what, act, exp, tol);
    end
  endtask

  // Compares the current outputs against the values for (x, y)
  task automatic check_result(input int x, input int y);
    real r;
    int  em, ea;
    r = $sqrt(real'(x * x + y * y));
    expect_near("R2", "out_valid", int'(out_valid), 1, 0);
    if (x == 0 && y == 0) begin
      expect_near("R8", "origin magnitude", int'(out_mag), 0, 0);
      expect_near("R8", "origin angle", int'(out_angle), 0, 0);
      return;
    end
    if (r >= 2051.0) begin
      expect_near("R7", "saturated magnitude", int'(out_mag), 2047, 0);
    end else begin
      em = (r > 2047.0) ? 2047 : int'(r);
      expect_near("R3", "magnitude", int'(out_mag), em, 4);
    end
    if (r >= 256.0) begin
      if (y == 0 && x < 0) begin
        expect_near("R6", "negative x axis angle", int'(out_angle), 804, 2);
        if (out_angle < 0) begin
          n_fail++;
          $display("FAIL R6 negative x axis sign: actual=%0d expected=positive", out_angle);
        end
      end else begin
        ea = int'($atan2(real'(y), real'(x)) * 256.0);
        expect_near("R4", "angle", int'(out_angle), ea, 4);
      end
    end
  endtask

  task automatic one_shot(input int x, input int y);
    in_x = 12'(x);
    in_y = 12'(y);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check_result(x, y);
  endtask

  task automatic quad_probe(input int x, input int y, input int exp_ang);
    one_shot(x, y);
    expect_near("R5", "quadrant angle", int'(out_angle), exp_ang, 3);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    int sx[4];
    int sy[4];
    int held_m, held_a;
    sx[0] = 256;   sy[0] = 0;
    sx[1] = -512;  sy[1] = 300;
    sx[2] = -700;  sy[2] = -700;
    sx[3] = 1000;  sy[3] = -1500;

    // R1: reset clears the outputs even with a sample presented
    @(negedge clk);
    in_x = 12'sd500; in_y = 12'sd500; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    expect_near("R1", "out_valid in reset", int'(out_valid), 0, 0);
    expect_near("R1", "out_mag in reset", int'(out_mag), 0, 0);
    expect_near("R1", "out_angle in reset", int'(out_angle), 0, 0);
    in_valid = 1'b0;
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R2: one-shot latency
    in_x = 12'sd256; in_y = 12'sd0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_near("R2", "out_valid one edge after capture", int'(out_valid), 0, 0);
    @(negedge clk);
    check_result(256, 0);
    @(negedge clk);
    expect_near("R2", "out_valid after idle", int'(out_valid), 0, 0);

    // R2: back-to-back stream, one result per clock
    for (int k = 0; k <= 4; k++) begin
      if (k < 4) begin
        in_x = 12'(sx[k]); in_y = 12'(sy[k]); in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
      if (k >= 1) check_result(sx[k-1], sy[k-1]);
    end

    // R9: outputs hold while idle and inputs move
    held_m = int'(out_mag);
    held_a = int'(out_angle);
    for (int k = 0; k < 3; k++) begin
      in_x = 12'(100 * k - 900);
      in_y = 12'(333 - 250 * k);
      @(negedge clk);
      expect_near("R9", "out_valid idle", int'(out_valid), 0, 0);
      expect_near("R9", "held magnitude", int'(out_mag), held_m, 0);
      expect_near("R9", "held angle", int'(out_angle), held_a, 0);
    end

    // R5: quadrant probes
    quad_probe(256, 256, 201);
    quad_probe(-256, -256, -603);
    quad_probe(0, 256, 402);
    quad_probe(0, -256, -402);

    // R6, R7, R8: seam, saturation and origin
    one_shot(-256, 0);
    one_shot(-2048, 0);
    one_shot(-2048, -2048);
    one_shot(2047, 2047);
    one_shot(0, 0);

    // Grid sweep over the whole input range (R3, R4, R6, R7, R8)
    for (int x = -2048; x < 2048; x += 32) begin
      for (int y = -2048; y < 2048; y += 32) begin
        one_shot(x, y);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule